// File: doc/BRIEF.md
# Command Block Status Tracker

This block holds a single memory-mapped command block for an accelerator. Software writes a 64-bit command word. When bit 0 of that word, the start bit, is set, the block launches the command: it sends a one-cycle start pulse to an execution engine and marks the command active. The engine later reports either a clean completion or an exception. The block then records the outcome in a 2-bit status field and a 4-bit substatus field. Both fields read back inside the command word.

On an exception the block captures a 20-bit cause vector. It then checks whether every asserted cause belongs to a fixed set of recoverable hardware faults. If so, it re-launches the same command by itself, up to `MAX_RETRY` attempts. Once the attempts are used up, or if any other cause is present, the command ends with status exception.

A status probe port models the software poll. A probe that finds the command still active returns on the fast path. Any other status is flagged for full completion handling.

Top module: `cmd_block_tracker`

## Requirements
- R1: After reset, status is idle (0), substatus, cause vector, retry count, launch, busyErr and rdData are all zero.
- R2: A write with wrData[0]=1 while status is not active (2) stores the word. It sets status to active, clears substatus, cause vector and retry count, and raises launch for exactly the one cycle after the write edge.
- R3: A write with wrData[0]=0 while not active stores the word and leaves status and substatus unchanged, with no launch. rdData always returns the stored word with bits 57:56 replaced by status and bits 61:58 by substatus.
- R4: A completion report (doneValid=1, doneExc=0) while active sets status to call-OS (3) if doneCallOs=1, else to idle (0). Substatus becomes {doneAbort, doneCode[2:0]}: bit 3 is the implicit-abort flag and bits 2:0 the queue code (0 none, 1 overflow, 2 limit, 3 page overflow, 4 atomic NACK, 5 put NACK).
- R5: An exception report (doneExc=1, which takes priority over doneCallOs) whose cause has any bit outside the retryable set {7,8,9,12,14,17,18} (mask 0x65380) sets status to exception (1), with substatus packed as in R4 and no launch.
- R6: An exception whose cause has no bit outside the retryable set, while retryCount < MAX_RETRY, increments retryCount, keeps status active and substatus unchanged, and raises launch for one cycle. Once retryCount equals MAX_RETRY, such an exception ends with status exception.
- R7: A write while status is active is ignored (rdData unchanged) and sets busyErr, which stays set until reset.
- R8: causeVec loads doneCause on every exception report while active, clears on a start write, and is otherwise unchanged.
- R9: A chkReq pulse gives chkValid in the next cycle. chkFast=1 if status was active at the request; otherwise chkFast=0. chkStatus carries the status at the request.
- R10: Completion and exception reports while status is not active change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Command word write strobe |
| wrData | input | 64 | Command word write data (bit 0 = start) |
| rdData | output | 64 | Command word readback with live status fields |
| launch | output | 1 | One-cycle start pulse to the execution engine |
| doneValid | input | 1 | Engine report valid |
| doneExc | input | 1 | Report is an exception |
| doneCallOs | input | 1 | Clean completion needs system software |
| doneCause | input | 20 | Exception cause vector |
| doneCode | input | 3 | Queue result code |
| doneAbort | input | 1 | Implicit abort active flag |
| status | output | 2 | Current status |
| substatus | output | 4 | Current substatus |
| causeVec | output | 20 | Captured cause vector |
| retryCount | output | 2 | Automatic re-launches made for the current command |
| busyErr | output | 1 | Sticky: a write arrived while active |
| chkReq | input | 1 | Status probe request |
| chkValid | output | 1 | Probe response valid |
| chkFast | output | 1 | Probe found the command active |
| chkStatus | output | 2 | Status seen by the probe |

## Verification
The bench sends exception causes drawn from three pools: only retryable bits, retryable bits mixed with at least one fatal bit, and the empty vector. These tell apart a mask test done as "no outside bit" from one done as "any inside bit". A directed run of back-to-back retryable exceptions reaches the attempt limit and shows the off-by-one boundary. Writes, reports and probes are also issued in every status, active or not. This separates the accepted paths from the ignored ones, and the sticky error flag from a level copy of the busy state.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int CAUSE_W = 20;
  localparam int STAT_LO = 56;
  localparam int SUB_LO  = 58;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXC    = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_CALLOS = 2'd3
  } cbStatus_e;

  localparam logic [CAUSE_W-1:0] RETRY_MASK =
      (CAUSE_W'(1) << 7)  | (CAUSE_W'(1) << 8)  | (CAUSE_W'(1) << 9) |
      (CAUSE_W'(1) << 12) | (CAUSE_W'(1) << 14) |
      (CAUSE_W'(1) << 17) | (CAUSE_W'(1) << 18);

  typedef struct packed {
    logic loadWord;
    logic clearRun;
    logic captureCause;
    logic bumpRetry;
  } dpStrobe_t;
endpackage

// File: rtl/cbt_ctrl.sv
module cbt_ctrl
  import cbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       wrStartBit,
  input  logic       doneValid,
  input  logic       doneExc,
  input  logic       doneCallOs,
  input  logic [2:0] doneCode,
  input  logic       doneAbort,
  input  logic       retryAllowed,
  input  logic       chkReq,
  output dpStrobe_t  strobe,
  output logic [1:0] status,
  output logic [3:0] substatus,
  output logic       launch,
  output logic       busyErr,
  output logic       chkValid,
  output logic       chkFast,
  output logic [1:0] chkStatus
);
  cbStatus_e statusQ, statusN;
  logic [3:0] subN;
  logic isActive, acceptWr, startNew, doneSeen, retryNow;

  always_comb begin
    isActive = (statusQ == ST_ACTIVE);
    acceptWr = wrEn && !isActive;
    startNew = acceptWr && wrStartBit;
    doneSeen = doneValid && isActive;
    retryNow = doneSeen && doneExc && retryAllowed;

    strobe.loadWord     = acceptWr;
    strobe.clearRun     = startNew;
    strobe.captureCause = doneSeen && doneExc;
    strobe.bumpRetry    = retryNow;

    statusN = statusQ;
    subN    = substatus;
    if (startNew) begin
      statusN = ST_ACTIVE;
      subN    = 4'd0;
    end else if (doneSeen && !retryNow) begin
      subN = {doneAbort, doneCode};
      if (doneExc)         statusN = ST_EXC;
      else if (doneCallOs) statusN = ST_CALLOS;
      else                 statusN = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ   <= ST_IDLE;
      substatus <= 4'd0;
      launch    <= 1'b0;
      busyErr   <= 1'b0;
      chkValid  <= 1'b0;
      chkFast   <= 1'b0;
      chkStatus <= 2'd0;
    end else begin
      statusQ   <= statusN;
      substatus <= subN;
      launch    <= startNew || retryNow;
      if (wrEn && isActive) busyErr <= 1'b1;
      chkValid  <= chkReq;
      if (chkReq) begin
        chkFast   <= isActive;
        chkStatus <= statusQ;
      end
    end
  end

  assign status = statusQ;
endmodule

// File: rtl/cbt_datapath.sv
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int CNT_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          strobe,
  input  logic [63:0]        wrData,
  input  logic [CAUSE_W-1:0] doneCause,
  input  logic [1:0]         status,
  input  logic [3:0]         substatus,
  output logic [63:0]        rdData,
  output logic [CAUSE_W-1:0] causeVec,
  output logic [CNT_W-1:0]   retryCount,
  output logic               retryAllowed
);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_RETRY);

  logic [1:0]  wordHi;
  logic [55:0] wordLo;
  logic        unusedFieldBits;
  logic        causeFatal;

  assign unusedFieldBits = ^wrData[61:56];
  assign causeFatal      = |(doneCause & ~RETRY_MASK);
  assign retryAllowed    = !causeFatal && (retryCount < CNT_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordHi     <= '0;
      wordLo     <= '0;
      causeVec   <= '0;
      retryCount <= '0;
    end else begin
      if (strobe.loadWord) begin
        wordHi <= wrData[63:62];
        wordLo <= wrData[55:0];
      end
      if (strobe.clearRun) begin
        causeVec   <= '0;
        retryCount <= '0;
      end else begin
        if (strobe.captureCause) causeVec <= doneCause;
        if (strobe.bumpRetry)    retryCount <= retryCount + 1'b1;
      end
    end
  end

  assign rdData = {wordHi, substatus, status, wordLo};
endmodule

// File: rtl/cmd_block_tracker.sv
module cmd_block_tracker
  import cbt_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int CNT_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [63:0]        wrData,
  output logic [63:0]        rdData,
  output logic               launch,
  input  logic               doneValid,
  input  logic               doneExc,
  input  logic               doneCallOs,
  input  logic [CAUSE_W-1:0] doneCause,
  input  logic [2:0]         doneCode,
  input  logic               doneAbort,
  output logic [1:0]         status,
  output logic [3:0]         substatus,
  output logic [CAUSE_W-1:0] causeVec,
  output logic [CNT_W-1:0]   retryCount,
  output logic               busyErr,
  input  logic               chkReq,
  output logic               chkValid,
  output logic               chkFast,
  output logic [1:0]         chkStatus
);
  dpStrobe_t strobe;
  logic      retryAllowed;

  cbt_ctrl u_ctrl (
    .clk, .rst_n, .wrEn,
    .wrStartBit(wrData[0]),
    .doneValid, .doneExc, .doneCallOs, .doneCode, .doneAbort,
    .retryAllowed, .chkReq, .strobe, .status, .substatus,
    .launch, .busyErr, .chkValid, .chkFast, .chkStatus
  );

  cbt_datapath #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_dp (
    .clk, .rst_n, .strobe, .wrData, .doneCause, .status, .substatus,
    .rdData, .causeVec, .retryCount, .retryAllowed
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import cbt_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int CNT_W     = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrEn,
  input logic [63:0]        wrData,
  input logic [63:0]        rdData,
  input logic               launch,
  input logic               doneValid,
  input logic               doneExc,
  input logic [CAUSE_W-1:0] doneCause,
  input logic [1:0]         status,
  input logic [CAUSE_W-1:0] causeVec,
  input logic [CNT_W-1:0]   retryCount,
  input logic               busyErr,
  input logic               chkReq,
  input logic               chkValid
);
  // R2
  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[0] && status != 2'd2) |=> (launch && status == 2'd2));
  // R7
  a_r7_busy_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && status == 2'd2) |=> busyErr);
  a_r7_busy_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busyErr |=> busyErr);
  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && status == 2'd2 && !doneValid) |=> $stable(rdData));
  // R5
  a_r5_fatal_cause_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneExc && status == 2'd2 && (doneCause & ~RETRY_MASK) != '0)
      |=> (status == 2'd1 && !launch));
  // R6
  a_r6_retry_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    retryCount <= CNT_W'(MAX_RETRY));
  // R8
  a_r8_cause_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd2 && !(wrEn && wrData[0])) |=> $stable(causeVec));
  // R9
  a_r9_probe_answers: assert property (@(posedge clk) disable iff (!rst_n)
    chkReq |=> chkValid);
  // R10
  a_r10_idle_report_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && status != 2'd2 && !wrEn) |=> ($stable(status) && !launch));
endmodule

bind cmd_block_tracker cbt_checker #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .launch(launch), .doneValid(doneValid), .doneExc(doneExc),
  .doneCause(doneCause), .status(status), .causeVec(causeVec),
  .retryCount(retryCount), .busyErr(busyErr), .chkReq(chkReq),
  .chkValid(chkValid)
);

// File: tb/sim_cmd_block_tracker.sv
`timescale 1ns/1ps
module sim_cmd_block_tracker;
  localparam int MAXR = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        launch;
  logic        doneValid = 1'b0, doneExc = 1'b0, doneCallOs = 1'b0, doneAbort = 1'b0;
  logic [19:0] doneCause = '0;
  logic [2:0]  doneCode = '0;
  logic [1:0]  status;
  logic [3:0]  substatus;
  logic [19:0] causeVec;
  logic [1:0]  retryCount;
  logic        busyErr;
  logic        chkReq = 1'b0;
  logic        chkValid, chkFast;
  logic [1:0]  chkStatus;

  always #5 clk = ~clk;

  cmd_block_tracker #(.MAX_RETRY(MAXR)) u0 (.*);

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model
  logic [63:0] mWord = '0;
  logic [1:0]  mStatus = '0;
  logic [3:0]  mSub = '0;
  logic [19:0] mCause = '0;
  int          mCnt = 0;
  bit          mErr = 0;
  bit          eLaunch = 0, eChkValid = 0, eChkFast = 0;
  logic [1:0]  eChkStatus = '0;

  function automatic logic [19:0] okMask();
    logic [19:0] m = '0;
    m[7] = 1; m[8] = 1; m[9] = 1; m[12] = 1; m[14] = 1; m[17] = 1; m[18] = 1;
    return m;
  endfunction

  function automatic bit mayRetry(logic [19:0] c);
    return (c & ~okMask()) == 20'd0;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "status", 64'(status), 64'(mStatus));
    check(tag, "substatus", 64'(substatus), 64'(mSub));
    check(tag, "causeVec", 64'(causeVec), 64'(mCause));
    check(tag, "retryCount", 64'(retryCount), 64'(mCnt));
    check(tag, "busyErr", 64'(busyErr), 64'(mErr));
    check(tag, "launch", 64'(launch), 64'(eLaunch));
    check(tag, "rdData", rdData, {mWord[63:62], mSub, mStatus, mWord[55:0]});
    check(tag, "chkValid", 64'(chkValid), 64'(eChkValid));
    if (eChkValid) begin
      check(tag, "chkFast", 64'(chkFast), 64'(eChkFast));
      check(tag, "chkStatus", 64'(chkStatus), 64'(eChkStatus));
    end
  endtask

  // one clock of stimulus; inputs set at negedge, results sampled at next negedge
  task automatic stepOp(string tag, bit wr, logic [63:0] wd, bit dv, bit dexc,
                        bit dcos, logic [19:0] dcause, logic [2:0] dcode,
                        bit dab, bit chk);
    bit act;
    wrEn = wr; wrData = wd; doneValid = dv; doneExc = dexc; doneCallOs = dcos;
    doneCause = dcause; doneCode = dcode; doneAbort = dab; chkReq = chk;
    @(posedge clk);
    act = (mStatus == 2'd2);
    eLaunch = 0;
    eChkValid = chk;
    if (chk) begin eChkFast = act; eChkStatus = mStatus; end
    if (wr && act) mErr = 1;
    if (wr && !act) begin
      mWord = wd;
      if (wd[0]) begin
        mStatus = 2'd2; mSub = 0; mCause = 0; mCnt = 0; eLaunch = 1;
      end
    end
    if (dv && act) begin
      if (dexc) begin
        mCause = dcause;
        if (mayRetry(dcause) && mCnt < MAXR) begin
          mCnt++; eLaunch = 1;
        end else begin
          mStatus = 2'd1; mSub = {dab, dcode};
        end
      end else begin
        mStatus = dcos ? 2'd3 : 2'd0; mSub = {dab, dcode};
      end
    end
    @(negedge clk);
    compareAll(tag);
    wrEn = 0; doneValid = 0; doneExc = 0; doneCallOs = 0; chkReq = 0;
  endtask

  function automatic logic [19:0] okCause();
    return 20'($urandom) & okMask();
  endfunction

  function automatic logic [19:0] badCause();
    logic [19:0] c = (20'($urandom) & ~okMask()) | okCause();
    if ((c & ~okMask()) == 0) c[0] = 1'b1;
    return c;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1");
    // R3: plain write
    stepOp("R3", 1, 64'hC3A5_0000_1234_5676, 0,0,0,0,0,0, 0);
    // R2: start
    stepOp("R2", 1, 64'h8000_0000_0000_0F01, 0,0,0,0,0,0, 0);
    // R7: write while active
    stepOp("R7", 1, 64'h1111_1111_1111_1111, 0,0,0,0,0,0, 0);
    // R9: probe while active
    stepOp("R9", 0, 0, 0,0,0,0,0,0, 1);
    // R6/R8: retryable exceptions up to the limit
    stepOp("R6", 0, 0, 1,1,0, 20'h00080, 3'd2, 0, 0);
    stepOp("R8", 0, 0, 1,1,0, 20'h60000, 3'd1, 0, 0);
    stepOp("R6", 0, 0, 1,1,0, 20'h00000, 3'd0, 0, 0);
    stepOp("R6", 0, 0, 1,1,1, 20'h01000, 3'd4, 1, 0);
    // R10: reports after completion are ignored
    stepOp("R10", 0, 0, 1,0,1, 0, 3'd5, 1, 0);
    stepOp("R10", 0, 0, 1,1,0, 20'hFFFFF, 3'd3, 0, 0);
    // R9: probe while not active
    stepOp("R9", 0, 0, 0,0,0,0,0,0, 1);
    // R5: fatal cause ends at once
    stepOp("R2", 1, 64'h0000_0000_0000_0001, 0,0,0,0,0,0, 0);
    stepOp("R5", 0, 0, 1,1,1, 20'h00180 | 20'h00001, 3'd1, 0, 0);
    // R4: call-OS then idle with abort flag
    stepOp("R2", 1, 64'h4000_0000_0000_00AB, 0,0,0,0,0,0, 0);
    stepOp("R4", 0, 0, 1,0,1, 0, 3'd3, 0, 0);
    stepOp("R2", 1, 64'h0000_0000_0000_0003, 0,0,0,0,0,0, 0);
    stepOp("R4", 0, 0, 1,0,0, 0, 3'd5, 1, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k = int'($urandom_range(0, 6));
      logic [63:0] wd = {$urandom, $urandom};
      case (k)
        0: stepOp("R2", 1, wd | 64'd1, 0,0,0,0,0,0, $urandom_range(0,1));
        1: stepOp("R3", 1, wd & ~64'd1, 0,0,0,0,0,0, 0);
        2: stepOp("R4", 0, 0, 1,0, $urandom_range(0,1), 0, 3'($urandom_range(0,5)),
                  $urandom_range(0,1), 0);
        3: stepOp("R6", $urandom_range(0,1), wd, 1,1, $urandom_range(0,1), okCause(),
                  3'($urandom_range(0,5)), $urandom_range(0,1), 0);
        4: stepOp("R5", 0, 0, 1,1,0, badCause(), 3'($urandom_range(0,5)),
                  $urandom_range(0,1), 0);
        5: stepOp("R9", 0, 0, 0,0,0,0,0,0, 1);
        default: stepOp("R10", 0, 0, $urandom_range(0,1), $urandom_range(0,1), 0,
                        okCause(), 3'd2, 0, 1);
      endcase
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule